// File: doc/BRIEF.md
# Protected Interrupt Vector Base Selector

This block holds an 8-bit control register that decides where the interrupt vector table is fetched from. The table starts either at address 0 of program memory or at the first word of a boot-loader region. The boot-region start address arrives on a configuration input. Moving the table takes a timed two-step unlock. Software first sets a change-enable bit. This opens a short window, and during that window a second write may load the new select value, provided the same write clears change-enable. Any select write that misses the window, or that leaves change-enable set, is dropped.

While the unlock runs, the block asks the interrupt controller to hold off delivery. The hold starts in the very cycle of the arming write. After an accepted select write, the hold lasts until the next instruction has completed, as marked by an instruction-boundary strobe. If no select write arrives, the hold ends when the window closes. The block never touches the global interrupt-enable flag, because it only drives a separate block line. Two lock settings add a second source for the same line. The first blocks interrupts while the program counter is in the application area and the table sits in the boot region. The second blocks them while the program counter is in the boot region and the table sits in the application area.

The register also carries a pull-up disable bit. That bit is written directly and needs no unlock.

Top module: `ivec_base_ctl`

## Requirements
- R1: After reset every register bit reads 0. Bit 0 is change-enable, bit 1 is vector select and bit 4 is pull-up disable; bits 7, 6, 5, 3 and 2 always read 0, whatever is written to them.
- R2: `vec_base` is 0 while the select bit is 0 and equals `boot_start` while it is 1.
- R3: The select bit changes only through a write with bit 0 = 0 made while change-enable reads 1; it takes bit 1 of that write. A select write with the window closed leaves it unchanged. So does a write that has bit 0 = 1.
- R4: A write with bit 0 = 1 sets change-enable from the next cycle, and `irq_block` is high in the cycle of that write. A write with bit 0 = 1 made while change-enable is already set reloads the full window.
- R5: If change-enable is not written, it reads 1 for exactly WIN_CYC cycles after the arming write (default 4) and then clears itself. `irq_block` drops in the same cycle unless another cause holds it.
- R6: An accepted select write clears change-enable. `irq_block` then stays high up to and including the cycle in which `insn_done` pulses after the write cycle. A pulse in the write cycle itself belongs to the writing instruction and does not end the hold.
- R7: Every register write loads bit 4 into the pull-up disable bit from the next cycle, whatever the state of the unlock. `pullup_dis` carries the bit.
- R8: The lock inputs raise `irq_block` in two cases. With select = 1, `lock_app` = 1 and `pc` < `boot_start`, it is high. With select = 0, `lock_boot` = 1 and `pc` >= `boot_start`, it is also high. In every other combination the lock inputs add no blocking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 8 | Register write data |
| insn_done | input | 1 | High in the last cycle of each executed instruction |
| boot_start | input | PC_W | Start word address of the boot-loader region |
| pc | input | PC_W | Current program counter |
| lock_app | input | 1 | Lock setting that guards the application area |
| lock_boot | input | 1 | Lock setting that guards the boot area |
| reg_rdata | output | 8 | Register read value |
| vec_base | output | PC_W | Base address of the interrupt vector table |
| irq_block | output | 1 | Hold off interrupt delivery |
| pullup_dis | output | 1 | Pull-up disable bit |

## Verification
A wrong select state shows up at once on `vec_base` and on bit 1 of `reg_rdata`, in the cycle after the write that caused it. A window counter that is off by one is visible at the window boundary. Bit 0 of `reg_rdata` and `irq_block` would change one cycle early or late, and a select write made in the last window cycle would be accepted or dropped wrongly. A stuck post-write hold keeps `irq_block` high past the first `insn_done` after the commit, so the fault shows in the following cycle.

// File: rtl/ivec_pkg.sv
package ivec_pkg;

  localparam int CE_BIT  = 0;
  localparam int SEL_BIT = 1;
  localparam int PUD_BIT = 4;
  localparam int REG_W   = 8;

  localparam logic [REG_W-1:0] LIVE_MASK =
    (REG_W'(1) << CE_BIT) | (REG_W'(1) << SEL_BIT) | (REG_W'(1) << PUD_BIT);

  typedef struct packed {
    logic pud;
    logic sel;
    logic ce;
  } ivec_state_t;

  function automatic logic [REG_W-1:0] pack_reg(input ivec_state_t s);
    logic [REG_W-1:0] v;
    v = '0;
    v[CE_BIT]  = s.ce;
    v[SEL_BIT] = s.sel;
    v[PUD_BIT] = s.pud;
    return v;
  endfunction

endpackage

// File: rtl/ivec_cfg_reg.sv
module ivec_cfg_reg
  import ivec_pkg::*;
#(
  parameter int WIN_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic        wr_ce,
  input  logic        wr_sel,
  input  logic        wr_pud,
  output ivec_state_t state,
  output logic        ev_arm,
  output logic        ev_commit,
  output logic        ev_expire
);
  localparam int CNT_W = $clog2(WIN_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic             ce_q, sel_q, pud_q;
  logic [CNT_W-1:0] cnt_q;

  assign ev_arm    = we & wr_ce;
  assign ev_commit = we & ~wr_ce & ce_q;
  assign ev_expire = ce_q & ~ev_arm & ~ev_commit & (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q  <= 1'b0;
      sel_q <= 1'b0;
      cnt_q <= '0;
    end else if (ev_arm) begin
      ce_q  <= 1'b1;
      cnt_q <= CNT_LOAD;
    end else if (ev_commit) begin
      ce_q  <= 1'b0;
      sel_q <= wr_sel;
      cnt_q <= '0;
    end else if (ce_q) begin
      if (ev_expire) ce_q <= 1'b0;
      cnt_q <= cnt_q - CNT_LAST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  pud_q <= 1'b0;
    else if (we) pud_q <= wr_pud;
  end

  assign state = '{pud: pud_q, sel: sel_q, ce: ce_q};
endmodule

// File: rtl/ivec_hold.sv
module ivec_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  logic insn_done,
  output logic hold
);
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  hold_q <= 1'b0;
    else if (commit)             hold_q <= 1'b1;
    else if (hold_q & insn_done) hold_q <= 1'b0;
  end

  assign hold = hold_q;
endmodule

// File: rtl/ivec_lock_gate.sv
module ivec_lock_gate #(
  parameter int PC_W = 14
) (
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] boot_start,
  input  logic            sel,
  input  logic            lock_app,
  input  logic            lock_boot,
  output logic            pc_in_boot,
  output logic            lock_block
);
  function automatic logic at_or_above(input logic [PC_W-1:0] a,
                                       input logic [PC_W-1:0] b);
    return a >= b;
  endfunction

  assign pc_in_boot = at_or_above(pc, boot_start);
  assign lock_block = (sel & lock_app & ~pc_in_boot) |
                      (~sel & lock_boot & pc_in_boot);
endmodule

// File: rtl/ivec_base_ctl.sv
module ivec_base_ctl
  import ivec_pkg::*;
#(
  parameter int PC_W    = 14,
  parameter int WIN_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [7:0]      reg_wdata,
  input  logic            insn_done,
  input  logic [PC_W-1:0] boot_start,
  input  logic [PC_W-1:0] pc,
  input  logic            lock_app,
  input  logic            lock_boot,
  output logic [7:0]      reg_rdata,
  output logic [PC_W-1:0] vec_base,
  output logic            irq_block,
  output logic            pullup_dis
);
  ivec_state_t st;
  logic ev_arm, ev_commit, ev_expire;
  logic hold_q, pc_in_boot, lock_block, seq_block;

  ivec_cfg_reg #(.WIN_CYC(WIN_CYC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(reg_we),
    .wr_ce(reg_wdata[CE_BIT]), .wr_sel(reg_wdata[SEL_BIT]),
    .wr_pud(reg_wdata[PUD_BIT]),
    .state(st), .ev_arm(ev_arm), .ev_commit(ev_commit), .ev_expire(ev_expire)
  );

  ivec_hold u_hold (
    .clk(clk), .rst_n(rst_n), .commit(ev_commit),
    .insn_done(insn_done), .hold(hold_q)
  );

  ivec_lock_gate #(.PC_W(PC_W)) u_lock (
    .pc(pc), .boot_start(boot_start), .sel(st.sel),
    .lock_app(lock_app), .lock_boot(lock_boot),
    .pc_in_boot(pc_in_boot), .lock_block(lock_block)
  );

  assign seq_block  = ev_arm | st.ce | hold_q;
  assign irq_block  = seq_block | lock_block;
  assign vec_base   = st.sel ? boot_start : '0;
  assign reg_rdata  = pack_reg(st);
  assign pullup_dis = st.pud;
endmodule

// File: rtl/ivec_base_ctl_chk.sv
module ivec_base_ctl_chk
  import ivec_pkg::*;
#(
  parameter int PC_W    = 14,
  parameter int WIN_CYC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [7:0]      reg_wdata,
  input logic            insn_done,
  input logic [PC_W-1:0] boot_start,
  input logic [PC_W-1:0] pc,
  input logic            lock_app,
  input logic            lock_boot,
  input logic [7:0]      reg_rdata,
  input logic [PC_W-1:0] vec_base,
  input logic            irq_block,
  input logic            pullup_dis,
  input logic            ev_arm,
  input logic            ev_commit,
  input logic            hold_q
);
  localparam int CW = $clog2(WIN_CYC + 2);
  logic [CW-1:0] open_cnt;
  logic          ce_now, sel_now;

  assign ce_now  = reg_rdata[CE_BIT];
  assign sel_now = reg_rdata[SEL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      open_cnt <= '0;
    else if (ev_arm) open_cnt <= '0;
    else if (ce_now) open_cnt <= open_cnt + CW'(1);
    else             open_cnt <= '0;
  end

  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~LIVE_MASK) == 8'h00); // R1
  AST_BASE_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    vec_base == (sel_now ? boot_start : {PC_W{1'b0}})); // R2
  AST_SEL_LOCKED_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_now |=> $stable(sel_now)); // R3
  AST_ARM_BLOCKS_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_wdata[CE_BIT]) |-> irq_block); // R4
  AST_WINDOW_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    ce_now |-> (open_cnt < CW'(WIN_CYC))); // R5
  AST_COMMIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |=> (irq_block && !ce_now)); // R6
  AST_HOLD_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && insn_done && !ev_commit) |=> !hold_q); // R6
  AST_PUD_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (pullup_dis == $past(reg_wdata[PUD_BIT]))); // R7
  AST_LOCK_APP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_now && lock_app && (pc < boot_start)) |-> irq_block); // R8
  AST_LOCK_BOOT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_now && lock_boot && (pc >= boot_start)) |-> irq_block); // R8
endmodule

bind ivec_base_ctl ivec_base_ctl_chk #(.PC_W(PC_W), .WIN_CYC(WIN_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .insn_done(insn_done), .boot_start(boot_start), .pc(pc),
  .lock_app(lock_app), .lock_boot(lock_boot), .reg_rdata(reg_rdata),
  .vec_base(vec_base), .irq_block(irq_block), .pullup_dis(pullup_dis),
  .ev_arm(ev_arm), .ev_commit(ev_commit), .hold_q(hold_q)
);

// File: tb/ivec_base_ctl_test.sv
`timescale 1ns/1ps
module ivec_base_ctl_test;
  localparam int PC_W = 14;
  localparam int WIN  = 4;
  localparam logic [PC_W-1:0] BOOT = 14'h1C00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic insn_done = 1'b0;
  logic [PC_W-1:0] pc = '0;
  logic lock_app = 1'b0, lock_boot = 1'b0;
  logic [7:0] reg_rdata;
  logic [PC_W-1:0] vec_base;
  logic irq_block, pullup_dis;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  ivec_base_ctl #(.PC_W(PC_W), .WIN_CYC(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .insn_done(insn_done), .boot_start(BOOT), .pc(pc),
    .lock_app(lock_app), .lock_boot(lock_boot), .reg_rdata(reg_rdata),
    .vec_base(vec_base), .irq_block(irq_block), .pullup_dis(pullup_dis)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d, input logic done = 1'b0);
    reg_we = 1'b1; reg_wdata = d; insn_done = done;
    tick();
    reg_we = 1'b0; insn_done = 1'b0;
  endtask

  function automatic logic [PC_W-1:0] exp_base(input logic s);
    return s ? BOOT : '0;
  endfunction

  task automatic t_reset();
    check("R1 reset rdata", reg_rdata, 8'h00);
    check("R2 reset base", vec_base, exp_base(1'b0));
    check("R1 reset block", irq_block, 1'b0);
    check("R7 reset pud", pullup_dis, 1'b0);
  endtask

  task automatic t_timeout();
    reg_we = 1'b1; reg_wdata = 8'h01; #1;
    check("R4 block in arm cycle", irq_block, 1'b1);
    @(posedge clk); @(negedge clk); reg_we = 1'b0;
    for (int i = 0; i < WIN; i++) begin
      check("R5 ce open", reg_rdata[0], 1'b1);
      check("R5 block open", irq_block, 1'b1);
      tick();
    end
    check("R5 ce self-clear", reg_rdata[0], 1'b0);
    check("R5 block released", irq_block, 1'b0);
    check("R3 sel kept", reg_rdata[1], 1'b0);
  endtask

  task automatic t_commit();
    wr(8'h01);
    wr(8'h02, 1'b1);
    check("R3 sel accepted", reg_rdata, 8'h02);
    check("R2 base boot", vec_base, exp_base(1'b1));
    check("R6 ce cleared", reg_rdata[0], 1'b0);
    check("R6 hold after commit", irq_block, 1'b1);
    tick();
    check("R6 hold waits", irq_block, 1'b1);
    insn_done = 1'b1; #1;
    check("R6 hold in done cycle", irq_block, 1'b1);
    @(negedge clk); insn_done = 1'b0; #1;
    check("R6 hold released", irq_block, 1'b0);
  endtask

  task automatic t_bad_writes();
    wr(8'h00);
    check("R3 closed write ignored", reg_rdata[1], 1'b1);
    wr(8'h01);
    tick(); tick();
    wr(8'h01);
    for (int i = 0; i < WIN - 1; i++) tick();
    check("R4 rearm reloads", reg_rdata[0], 1'b1);
    tick();
    check("R5 rearm window ends", reg_rdata[0], 1'b0);
    check("R3 ce=1 write no sel change", reg_rdata[1], 1'b1);
    wr(8'h01);
    for (int i = 0; i < WIN; i++) tick();
    wr(8'h00);
    check("R3 late write ignored", reg_rdata[1], 1'b1);
    wr(8'h01);
    for (int i = 0; i < WIN - 1; i++) tick();
    wr(8'h00);
    check("R3 last-cycle write taken", reg_rdata[1], 1'b0);
    check("R2 base app", vec_base, exp_base(1'b0));
    insn_done = 1'b1; tick(); insn_done = 1'b0;
    check("R6 released", irq_block, 1'b0);
  endtask

  task automatic t_pud();
    wr(8'h10);
    check("R7 pud set", pullup_dis, 1'b1);
    check("R7 pud rdata", reg_rdata, 8'h10);
    check("R7 no unlock side effect", irq_block, 1'b0);
    wr(8'hEC);
    check("R1 spare bits read zero", reg_rdata, 8'h00);
    check("R7 pud cleared", pullup_dis, 1'b0);
  endtask

  task automatic t_lock();
    lock_boot = 1'b1; pc = BOOT; #1;
    check("R8 boot lock in boot", irq_block, 1'b1);
    pc = BOOT - 1; #1;
    check("R8 boot lock in app", irq_block, 1'b0);
    lock_app = 1'b1; lock_boot = 1'b0; #1;
    check("R8 app lock sel0", irq_block, 1'b0);
    @(negedge clk);
    wr(8'h01); wr(8'h02); insn_done = 1'b1; tick(); insn_done = 1'b0;
    check("R8 app lock in app", irq_block, 1'b1);
    pc = BOOT; #1;
    check("R8 app lock in boot", irq_block, 1'b0);
    lock_app = 1'b0; pc = 14'h0010; #1;
    check("R8 no lock", irq_block, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timeout();
    t_commit();
    t_bad_writes();
    t_pud();
    t_lock();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule